// File: doc/BRIEF.md
# Two-Channel Wiper Register Controller with I2C Slave

This block is the digital front end of a two-channel digital potentiometer. It is a slave on an I2C-compatible two-wire bus and holds two 8-bit wiper codes, a shutdown flag for each channel and two general-purpose logic outputs. A bus master writes to it with three kinds of byte, in this order: an address byte, an instruction byte and one or more data bytes. The instruction byte selects a channel, can force that channel to midscale or into shutdown, and sets the two logic outputs. Each data byte that follows, up to the STOP, becomes the new code of the selected channel.

A read has no instruction byte. Once the address byte with the read flag is acknowledged, the block returns the code of the channel that the last write selected, most significant bit first. As long as the master acknowledges, the block repeats that code. Both bus lines are sampled on the system clock through two-stage synchronisers, and all bus events come from edges on the synchronised lines. The system clock must run at least eight times faster than SCL. SDA is open drain: the block only asserts an enable that pulls the line low.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: After reset, both wiper codes are 0x80, both shutdown flags are 0, both logic outputs are 0, and the block does not pull SDA.
- R2: The block acknowledges an address byte only when it equals {0,1,0,1,1, strap_i[1], strap_i[0], R/W}, sent MSB first. On any other address it leaves SDA released for the rest of that transaction and changes no output.
- R3: A write whose instruction byte has bit 7 = 0 loads the data byte into wiper0_o, and one with bit 7 = 1 loads it into wiper1_o. The other channel keeps its code. The instruction byte and every data byte are acknowledged.
- R4: Several data bytes in one write all go to the same selected channel, so the channel holds the last byte sent before STOP.
- R5: Instruction bit 6 = 1 sets the selected channel to 0x80. Any data bytes after it in the same write are acknowledged but leave the code at 0x80.
- R6: Instruction bit 5 is copied into the shutdown flag of the selected channel (shut_o[0] or shut_o[1]). Shutting a channel down does not change its wiper code.
- R7: While shdn_n_i is low, both shut_o bits are 1, without waiting for a clock edge. The wiper codes are not changed, and the earlier flags come back when the pin returns high.
- R8: When an instruction byte is accepted, bit 4 goes to gpo_o[1] and bit 3 goes to gpo_o[0]. Bits 2 to 0 have no effect.
- R9: After a read address is acknowledged, the block sends the code of the channel selected by the last instruction, MSB first. After the master's NACK it releases SDA.
- R10: When the master acknowledges a read byte, the block sends the same code again in the next byte.
- R11: A STOP or START in the middle of a byte ends the byte. A data byte cut off this way changes no wiper code.
- R12: The block changes its SDA pull only after an SCL falling edge, a START or a STOP, never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Address straps: bit 1 = upper strap, bit 0 = lower strap |
| shdn_n_i | input | 1 | Active-low asynchronous shutdown of both channels |
| wiper0_o | output | 8 | Wiper code of channel 0 |
| wiper1_o | output | 8 | Wiper code of channel 1 |
| shut_o | output | 2 | Shutdown state per channel (bit n = channel n) |
| gpo_o | output | 2 | Latched logic outputs: bit 1 = instruction bit 4, bit 0 = instruction bit 3 |

## Verification
The bench mixes directed sequences with random ones. The random transactions cover writes with random instruction bytes and zero to three data bytes, reads of one or two bytes, and addresses that differ only in the strap bits. The strap setting changes between transactions. Random instruction bytes try every combination of channel, midscale, shutdown and output bits, so the check shows whether the code landed in the right channel and whether the midscale lock held for the rest of the write. The directed cases cover what random traffic rarely produces: a data byte cut off by STOP, a repeated read with master ACK, the shutdown pin pulsed with no bus traffic, and a wrong address followed by data bytes that must be ignored.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
  localparam int BYTE_W   = 8;
  localparam int WIPER_W  = 8;
  localparam int NCH      = 2;
  localparam logic [4:0] ADDR_FIXED = 5'b01011;

  // instruction byte bit positions (decoded by the register logic)
  localparam int IB_CH  = 7;
  localparam int IB_MID = 6;
  localparam int IB_SD  = 5;
  localparam int IB_O2  = 4;
  localparam int IB_O1  = 3;

  typedef enum logic [1:0] {K_ADDR, K_INSTR, K_DATA} byte_kind_e;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_IGNORE} eng_st_e;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [1:0] strap);
    return (b[BYTE_W-1:3] == ADDR_FIXED) && (b[2:1] == strap);
  endfunction

  function automatic logic [WIPER_W-1:0] midscale_code();
    return WIPER_W'(1) << (WIPER_W - 1);
  endfunction
endpackage

// File: rtl/dpot_line_sync.sv
`timescale 1ns/1ps
module dpot_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_prev, sda_prev, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= '1;
      sda_q    <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_q    <= {scl_q[STAGES-2:0], scl_i};
      sda_q    <= {sda_q[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/dpot_bus_engine.sv
`timescale 1ns/1ps
module dpot_bus_engine
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              instr_stb,
  output logic              data_stb,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              st_ignore
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  eng_st_e            st;
  byte_kind_e         kind;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-2:0]  shift;
  logic [BYTE_W-1:0]  tx_sh;
  logic               rw_q, ack_pend, mack_ok;
  logic [BYTE_W-1:0]  full_byte;

  assign full_byte = {shift, sda_s};
  assign st_ignore = (st == S_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_ADDR;
      cnt       <= '0;
      shift     <= '0;
      tx_sh     <= '0;
      rw_q      <= 1'b0;
      ack_pend  <= 1'b0;
      mack_ok   <= 1'b0;
      sda_oe    <= 1'b0;
      instr_stb <= 1'b0;
      data_stb  <= 1'b0;
      rx_byte   <= '0;
    end else begin
      instr_stb <= 1'b0;
      data_stb  <= 1'b0;
      if (start_ev) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              shift <= full_byte[BYTE_W-2:0];
              cnt   <= cnt + 1'b1;
              if (cnt == CNT_LAST) begin
                rx_byte <= full_byte;
                case (kind)
                  K_ADDR: begin
                    ack_pend <= addr_hit(full_byte, strap);
                    rw_q     <= full_byte[0];
                  end
                  K_INSTR: begin
                    ack_pend  <= 1'b1;
                    instr_stb <= 1'b1;
                  end
                  default: begin
                    ack_pend <= 1'b1;
                    data_stb <= 1'b1;
                  end
                endcase
              end
            end else if (scl_fall && cnt == CNT_FULL) begin
              if (ack_pend) begin
                st     <= S_ACK;
                sda_oe <= 1'b1;
              end else begin
                st <= S_IGNORE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_ADDR && rw_q) begin
                st     <= S_TX;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                st     <= S_RX;
                sda_oe <= 1'b0;
                kind   <= (kind == K_ADDR) ? K_INSTR : K_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                st     <= S_MACK;
                sda_oe <= 1'b0;
              end else begin
                tx_sh  <= tx_sh << 1;
                sda_oe <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack_ok) begin
                st     <= S_TX;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                st <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_wiper_regs.sv
`timescale 1ns/1ps
module dpot_wiper_regs
  import dpot_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   instr_stb,
  input  logic                   data_stb,
  input  logic [BYTE_W-1:0]      rx_byte,
  input  logic                   shdn_n_i,
  output logic [NCH*WIPER_W-1:0] wipers,
  output logic [NCH-1:0]         shut,
  output logic [1:0]             gpo,
  output logic [WIPER_W-1:0]     rd_data,
  output logic                   mid_lock
);
  logic           sel;
  logic [NCH-1:0] sd_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= 1'b0;
      mid_lock <= 1'b0;
      gpo      <= '0;
    end else if (instr_stb) begin
      sel      <= rx_byte[IB_CH];
      mid_lock <= rx_byte[IB_MID];
      gpo      <= {rx_byte[IB_O2], rx_byte[IB_O1]};
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [WIPER_W-1:0] code_r;
    logic               sd_r;
    logic               hit_instr, hit_data;

    assign hit_instr = instr_stb && (rx_byte[IB_CH] == 1'(c));
    assign hit_data  = data_stb && !mid_lock && (sel == 1'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_r <= midscale_code();
        sd_r   <= 1'b0;
      end else if (hit_instr) begin
        sd_r <= rx_byte[IB_SD];
        if (rx_byte[IB_MID]) code_r <= midscale_code();
      end else if (hit_data) begin
        code_r <= rx_byte[WIPER_W-1:0];
      end
    end

    assign wipers[c*WIPER_W +: WIPER_W] = code_r;
    assign sd_vec[c] = sd_r;
  end

  assign shut    = sd_vec | {NCH{~shdn_n_i}};
  assign rd_data = wipers[sel*WIPER_W +: WIPER_W];
endmodule

// File: rtl/dpot_i2c_ctrl.sv
`timescale 1ns/1ps
module dpot_i2c_ctrl
  import dpot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [1:0]         strap_i,
  input  logic               shdn_n_i,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic [NCH-1:0]     shut_o,
  output logic [1:0]         gpo_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic instr_stb, data_stb, st_ignore, mid_lock;
  logic [BYTE_W-1:0]      rx_byte;
  logic [WIPER_W-1:0]     rd_data;
  logic [NCH*WIPER_W-1:0] wipers;

  dpot_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  dpot_bus_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(strap_i), .rd_data(rd_data), .sda_oe(sda_oe),
    .instr_stb(instr_stb), .data_stb(data_stb), .rx_byte(rx_byte),
    .st_ignore(st_ignore)
  );

  dpot_wiper_regs u_regs (
    .clk(clk), .rst_n(rst_n), .instr_stb(instr_stb), .data_stb(data_stb),
    .rx_byte(rx_byte), .shdn_n_i(shdn_n_i), .wipers(wipers), .shut(shut_o),
    .gpo(gpo_o), .rd_data(rd_data), .mid_lock(mid_lock)
  );

  assign wiper0_o = wipers[0 +: WIPER_W];
  assign wiper1_o = wipers[WIPER_W +: WIPER_W];
endmodule

// File: rtl/dpot_i2c_chk.sv
`timescale 1ns/1ps
module dpot_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       st_ignore,
  input logic       instr_stb,
  input logic       data_stb,
  input logic [7:0] rx_byte,
  input logic       mid_lock,
  input logic [7:0] wiper0_o,
  input logic [7:0] wiper1_o,
  input logic       shdn_n_i,
  input logic [1:0] shut_o
);
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    st_ignore |-> !sda_oe);  // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_stb && !data_stb) |=> ($stable(wiper0_o) && $stable(wiper1_o)));  // R3
  AST_MID_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && mid_lock) |=> ($stable(wiper0_o) && $stable(wiper1_o)));  // R5
  AST_MID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_stb && rx_byte[6] && !rx_byte[7]) |=> (wiper0_o == 8'h80));  // R5
  AST_SD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_stb && !rx_byte[6]) |=> ($stable(wiper0_o) && $stable(wiper1_o)));  // R6
  AST_PIN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |-> (shut_o == 2'b11));  // R7
  AST_SDA_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));  // R12
endmodule

bind dpot_i2c_ctrl dpot_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .st_ignore(st_ignore),
  .instr_stb(instr_stb), .data_stb(data_stb), .rx_byte(rx_byte),
  .mid_lock(mid_lock), .wiper0_o(wiper0_o), .wiper1_o(wiper1_o),
  .shdn_n_i(shdn_n_i), .shut_o(shut_o)
);

// File: tb/dpot_i2c_ctrl_tb.sv
`timescale 1ns/1ps
module dpot_i2c_ctrl_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, shdn_n = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sda_oe;
  logic [7:0] wiper0, wiper1;
  logic [1:0] shut, gpo;
  wire sda_line = sda_m & ~sda_oe;

  dpot_i2c_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .shdn_n_i(shdn_n), .wiper0_o(wiper0), .wiper1_o(wiper1),
    .shut_o(shut), .gpo_o(gpo)
  );

  int checks = 0, errors = 0, r12_bad = 0;
  logic done = 1'b0;

  // bench model of the registers
  logic [7:0] m_w [2];
  logic [1:0] m_sd, m_gpo;
  logic       m_sel, m_lock;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rd);
    return {5'b01011, s, rd};
  endfunction

  task automatic model_instr(input logic [7:0] b);
    m_sel  = b[7];
    m_lock = b[6];
    if (b[6]) m_w[b[7]] = 8'h80;
    m_sd[b[7]] = b[5];
    m_gpo = {b[4], b[3]};
  endtask

  task automatic model_data(input logic [7:0] b);
    if (!m_lock) m_w[m_sel] = b;
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = ~sda_line;
    qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0;
    end
    sda_m = ~mack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " wiper0"}, 32'(wiper0), 32'(m_w[0]));
    chk({tag, " wiper1"}, 32'(wiper1), 32'(m_w[1]));
    chk({tag, " shut"},   32'(shut),   32'(m_sd));
    chk({tag, " gpo"},    32'(gpo),    32'(m_gpo));
  endtask

  // full write: address, instruction, n data bytes, stop
  task automatic do_write(input logic [1:0] s, input logic [7:0] ins,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n, input string tag);
    logic ack;
    logic hit;
    hit = (s == strap);
    bus_start();
    send_byte(addr_byte(s, 1'b0), ack);
    chk({tag, " R2 addr ack"}, 32'(ack), 32'(hit));
    send_byte(ins, ack);
    chk({tag, " R3 instr ack"}, 32'(ack), 32'(hit));
    if (hit) model_instr(ins);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      send_byte(d, ack);
      chk({tag, " R3 data ack"}, 32'(ack), 32'(hit));
      if (hit) model_data(d);
    end
    bus_stop();
    qw();
  endtask

  task automatic do_read(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    chk({tag, " R9 read addr ack"}, 32'(ack), 32'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k != n - 1);
      chk({tag, (k == 0) ? " R9 read data" : " R10 repeat data"}, 32'(b), 32'(m_w[m_sel]));
    end
    bus_stop();
    qw();
    chk({tag, " R9 sda released"}, 32'(sda_oe), 32'd0);
  endtask

  // R12 monitor: the pull may not change during an SCL high phase
  logic scl_d = 1'b1, oe_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_d && (oe_d !== sda_oe)) r12_bad++;
    scl_d <= scl_m;
    oe_d  <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    void'($urandom(32'h0D5E_ED01));
    m_w[0] = 8'h80; m_w[1] = 8'h80; m_sd = 2'b00; m_gpo = 2'b00;
    m_sel = 1'b0; m_lock = 1'b0;
    strap = 2'b10;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_regs("R1 reset");
    chk("R1 sda idle", 32'(sda_oe), 32'd0);

    // R3 channel 0 write
    do_write(strap, 8'h00, 8'h3C, 8'h00, 8'h00, 1, "R3 ch0");
    check_regs("R3 ch0");

    // R4 streamed bytes to channel 1, R8 outputs (bits 2..0 set, ignored)
    do_write(strap, 8'h9F, 8'h11, 8'h22, 8'h33, 3, "R4 stream");
    check_regs("R4 R8 stream");
    chk("R4 last byte wins", 32'(wiper1), 32'h33);
    chk("R8 gpo", 32'(gpo), 32'd3);

    // R5 midscale lock
    do_write(strap, 8'hC0, 8'h55, 8'h66, 8'h00, 2, "R5 mid");
    chk("R5 midscale", 32'(wiper1), 32'h80);
    check_regs("R5 mid");

    // R6 shutdown flag, code kept
    do_write(strap, 8'h20, 8'h44, 8'h00, 8'h00, 1, "R6 sd");
    chk("R6 shut flag", 32'(shut), 32'd1);
    do_write(strap, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R6 clear");
    chk("R6 code kept", 32'(wiper0), 32'h44);
    check_regs("R6 clear");

    // R7 asynchronous pin, between clock edges
    @(negedge clk); #1 shdn_n = 1'b0; #0.5;
    chk("R7 pin shut", 32'(shut), 32'd3);
    repeat (4) @(negedge clk);
    chk("R7 codes kept", {16'd0, wiper1, wiper0}, {16'd0, m_w[1], m_w[0]});
    shdn_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 release", 32'(shut), 32'(m_sd));

    // R2 wrong address: no ack, later bytes ignored
    do_write(strap ^ 2'b01, 8'h80, 8'h07, 8'h00, 8'h00, 1, "R2 miss");
    check_regs("R2 miss");

    // R9 read, R10 repeated read
    do_read(1, "R9");
    do_read(2, "R10");

    // R11 data byte cut off by STOP
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h80, ack);
    model_instr(8'h80);
    send_bits(8'hA5, 4);
    bus_stop();
    qw();
    check_regs("R11 stop abort");
    // R11 cut off by repeated START, then a normal read
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h00, ack);
    model_instr(8'h00);
    send_bits(8'h5A, 5);
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    chk("R11 restart ack", 32'(ack), 32'd1);
    begin
      logic [7:0] b;
      recv_byte(b, 1'b0);
      chk("R11 restart read", 32'(b), 32'(m_w[0]));
    end
    bus_stop();
    qw();
    check_regs("R11 restart");

    // random traffic
    for (int t = 0; t < 30; t++) begin
      int op;
      op = $urandom_range(0, 3);
      strap = 2'($urandom_range(0, 3));
      qw();
      if (op <= 1)
        do_write(strap, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 $urandom_range(0, 3), "R3 random write");
      else if (op == 2)
        do_read($urandom_range(1, 2), "R9 random read");
      else
        do_write(strap ^ 2'($urandom_range(1, 3)), 8'($urandom), 8'($urandom),
                 8'h00, 8'h00, 1, "R2 random miss");
      check_regs("R4 random");
    end

    chk("R12 no change in SCL high", 32'(r12_bad), 32'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule